// File: doc/BRIEF.md
# Multi-Function General Purpose Timer Bank

A bank of six independent 16-bit up-counters sits behind a small synchronous register bus. Each counter has a power-of-two prescaler and two compare units. It can take its count tick from one of two tick-enable inputs. A compare unit raises a sticky event flag when the counter steps onto a matching value. Software clears a flag by writing 1 to it.

Each timer's configuration is write-once. The first write to its setup word fixes the following fields until reset:

- the prescaler,
- the clock select,
- the two compare modes,
- three stored-only bits.

After that first write, only the run bit and the flag-clear bits have an effect.

A per-timer reset mask chooses which timers turn a compare-2 event into a one-cycle system reset request. Compare units programmed for event mode also drive a level event output.

A setup word that reads zero tells software that the timer has never been claimed. Software may reload the counter register at any time.

Top module: `mfgpt_bank`

## Requirements
- R1: Each timer N (0..5) owns an 8-byte window at byte address 8*N:
  - compare 1 at +0
  - compare 2 at +2
  - counter at +4
  - setup at +6

  The reset mask lives at byte 0x30, bits [5:0], one bit per timer. Odd addresses and addresses outside these words read 0, and writes to them are ignored.
- R2: After reset every register reads 0, and the reset-request and event outputs are low.
- R3: Setup word layout:
  - [3:0] prescale exponent
  - 4: clock select
  - 5, 11, 12: stored-only bits
  - [7:6]: compare-1 mode
  - [9:8]: compare-2 mode
  - 13: compare-1 flag
  - 14: compare-2 flag
  - 15: run
  - 10: always reads 0

  The first setup write stores bits [12:0]. Later writes change only bit 15 and the flag-clear bits.
- R4: While run is set, the counter advances once per 2^prescale selected ticks (exponent 0..15). The divider restarts from zero whenever run is clear.
- R5: Clock select 0 takes ticks from `tick_a`; clock select 1 takes ticks from `tick_b`.
- R6: The counter counts up and wraps from 0xFFFF to 0. It holds while run is clear. A bus write loads it, and in the same cycle that write takes precedence over an advance.
- R7: Compare modes:
  - 0: never fires
  - 1 and 3: set the flag when the counter advances onto a value equal to the compare register
  - 2: sets the flag when the counter advances onto a value greater than or equal to it

  Bus loads of the counter never fire a compare.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A compare that fires in the same cycle keeps the flag set.
- R9: `rst_req[N]` is high for exactly the one cycle after timer N's compare-2 flag goes from 0 to 1, and only if mask bit N is 1 during that cycle.
- R10: `evt_out[N]` is high while a flag of timer N is set and that compare is programmed in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| tick_a | input | 1 | Tick enable for clock select 0 |
| tick_b | input | 1 | Tick enable for clock select 1 |
| rst_req | output | 6 | One-cycle reset request per timer |
| evt_out | output | 6 | Event-mode level output per timer |

## Verification
The bench first targets the lock on the setup word. It tries to rewrite the prescaler and modes after the first write, and a design that forgets the lock would show the new values or change its count rate. It then drives a counter across 0xFFFF, and lands a bus load and an advance in the same cycle. A design that got this wrong would stick at the top value or lose the loaded value.

Compare-2 events are raised both with the mask bit set and with it clear, and with flag clears issued while the compare fires. A faulty design would emit requests from unmasked timers, hold the request longer than one cycle, or drop a fresh event. The bench also sends writes to odd and unmapped addresses, which a loose decoder would let corrupt a timer.

// File: rtl/mfgpt_pkg.sv
package mfgpt_pkg;

  localparam int DW    = 16;
  localparam int PS_W  = 4;
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam int CFG_W = 13;

  typedef enum logic [1:0] {
    CMP_OFF = 2'd0,
    CMP_EQ  = 2'd1,
    CMP_GE  = 2'd2,
    CMP_EVT = 2'd3
  } cmp_mode_e;

  // word index inside a timer window
  localparam logic [1:0] WIN_CMP1  = 2'd0;
  localparam logic [1:0] WIN_CMP2  = 2'd1;
  localparam logic [1:0] WIN_CNT   = 2'd2;
  localparam logic [1:0] WIN_SETUP = 2'd3;

  localparam int SB_CLKSEL = 4;
  localparam int SB_F1     = 13;
  localparam int SB_F2     = 14;
  localparam int SB_RUN    = 15;

  // stored config bits readable back: all of [12:0] except bit 10
  localparam logic [CFG_W-1:0] CFG_RD_MASK = 13'h1BFF;

  function automatic logic [DIV_W-1:0] presc_last(input logic [PS_W-1:0] ps);
    return DIV_W'((32'd1 << ps) - 32'd1);
  endfunction

  function automatic logic cmp_hit(input cmp_mode_e m, input logic [DW-1:0] v,
                                   input logic [DW-1:0] r);
    case (m)
      CMP_EQ, CMP_EVT: return v == r;
      CMP_GE:          return v >= r;
      default:         return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] cnt_inc(input logic [DW-1:0] v);
    return v + 1'b1;
  endfunction

endpackage

// File: rtl/mfgpt_prescaler.sv
module mfgpt_prescaler
  import mfgpt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            step_o
);

  logic [DIV_W-1:0] div_q;

  assign step_o = run_i & tick_i & (div_q == presc_last(ps_i));

  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= '0;
    else if (!run_i) div_q <= '0;
    else if (tick_i) div_q <= step_o ? '0 : div_q + 1'b1;
  end

  // R4
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> div_q <= presc_last(ps_i));

  // R4
  div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> div_q == '0);

endmodule

// File: rtl/mfgpt_cmp.sv
module mfgpt_cmp
  import mfgpt_pkg::*;
(
  input  cmp_mode_e        mode_i,
  input  logic [DW-1:0]    ref_i,
  input  logic [DW-1:0]    val_i,
  input  logic             fire_i,
  output logic             hit_o
);

  assign hit_o = fire_i & cmp_hit(mode_i, val_i, ref_i);

endmodule

// File: rtl/mfgpt_timer.sv
module mfgpt_timer
  import mfgpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_a,
  input  logic          tick_b,
  input  logic          wr_cmp1_i,
  input  logic          wr_cmp2_i,
  input  logic          wr_cnt_i,
  input  logic          wr_setup_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rst_en_i,
  output logic [DW-1:0] cmp1_o,
  output logic [DW-1:0] cmp2_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] setup_o,
  output logic          rst_req_o,
  output logic          evt_o
);

  logic             locked_q;
  logic [CFG_W-1:0] cfg_q;
  logic             run_q, f1_q, f2_q, f2_d;
  logic [DW-1:0]    cmp1_q, cmp2_q, cnt_q;

  logic [PS_W-1:0]  ps;
  cmp_mode_e        mode [2];
  logic [DW-1:0]    cref [2];
  logic             hit  [2];
  logic             tick_sel, step, advance;
  logic [DW-1:0]    cnt_nx;
  logic             clr1, clr2;

  assign ps       = cfg_q[PS_W-1:0];
  assign mode[0]  = cmp_mode_e'(cfg_q[7:6]);
  assign mode[1]  = cmp_mode_e'(cfg_q[9:8]);
  assign cref[0]  = cmp1_q;
  assign cref[1]  = cmp2_q;
  assign tick_sel = cfg_q[SB_CLKSEL] ? tick_b : tick_a;
  assign cnt_nx   = cnt_inc(cnt_q);
  assign advance  = step & ~wr_cnt_i;
  assign clr1     = wr_setup_i & wdata_i[SB_F1];
  assign clr2     = wr_setup_i & wdata_i[SB_F2];

  mfgpt_prescaler u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_q),
    .tick_i (tick_sel),
    .ps_i   (ps),
    .step_o (step)
  );

  for (genvar k = 0; k < 2; k++) begin : g_cmp
    mfgpt_cmp u_cmp (
      .mode_i (mode[k]),
      .ref_i  (cref[k]),
      .val_i  (cnt_nx),
      .fire_i (advance),
      .hit_o  (hit[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      cfg_q    <= '0;
      run_q    <= 1'b0;
      f1_q     <= 1'b0;
      f2_q     <= 1'b0;
      f2_d     <= 1'b0;
      cmp1_q   <= '0;
      cmp2_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_cmp1_i) cmp1_q <= wdata_i;
      if (wr_cmp2_i) cmp2_q <= wdata_i;
      if (wr_cnt_i)     cnt_q <= wdata_i;
      else if (advance) cnt_q <= cnt_nx;
      if (wr_setup_i) begin
        run_q <= wdata_i[SB_RUN];
        if (!locked_q) begin
          cfg_q    <= wdata_i[CFG_W-1:0];
          locked_q <= 1'b1;
        end
      end
      f1_q <= (f1_q & ~clr1) | hit[0];
      f2_q <= (f2_q & ~clr2) | hit[1];
      f2_d <= f2_q;
    end
  end

  assign cmp1_o    = cmp1_q;
  assign cmp2_o    = cmp2_q;
  assign cnt_o     = cnt_q;
  assign setup_o   = {run_q, f2_q, f1_q, cfg_q & CFG_RD_MASK};
  assign rst_req_o = f2_q & ~f2_d & rst_en_i;
  assign evt_o     = (f1_q & (mode[0] == CMP_EVT)) | (f2_q & (mode[1] == CMP_EVT));

  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cfg_q));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_cnt_i) |=> $stable(cnt_q));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> cnt_q == $past(cnt_q) + 16'd1);

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f2_q) |-> $past(hit[1]));

  // R7
  off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] == CMP_OFF) |-> !hit[0]);

  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

endmodule

// File: rtl/mfgpt_bank.sv
module mfgpt_bank
  import mfgpt_pkg::*;
#(
  parameter int NUM_TMR = 6,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tick_a,
  input  logic              tick_b,
  output logic [NUM_TMR-1:0] rst_req,
  output logic [NUM_TMR-1:0] evt_out
);

  localparam int WIN_SH    = 3;
  localparam int IDX_W     = ADDR_W - WIN_SH;
  localparam int WORD_W    = ADDR_W - 1;
  localparam int MASK_WORD = NUM_TMR * 4;

  logic [IDX_W-1:0]  tidx;
  logic [1:0]        wsel;
  logic [WORD_W-1:0] word_addr;
  logic              aligned, wr_ok, mask_sel;
  logic [NUM_TMR-1:0] mask_q;
  logic [DW-1:0]     rd_word [NUM_TMR][4];

  assign tidx      = bus_addr[ADDR_W-1:WIN_SH];
  assign wsel      = bus_addr[2:1];
  assign word_addr = bus_addr[ADDR_W-1:1];
  assign aligned   = ~bus_addr[0];
  assign wr_ok     = bus_wr & aligned;
  assign mask_sel  = word_addr == WORD_W'(MASK_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n)                mask_q <= '0;
    else if (wr_ok && mask_sel) mask_q <= bus_wdata[NUM_TMR-1:0];
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic tsel;
    assign tsel = wr_ok & (tidx == IDX_W'(i));

    mfgpt_timer u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_a     (tick_a),
      .tick_b     (tick_b),
      .wr_cmp1_i  (tsel & (wsel == WIN_CMP1)),
      .wr_cmp2_i  (tsel & (wsel == WIN_CMP2)),
      .wr_cnt_i   (tsel & (wsel == WIN_CNT)),
      .wr_setup_i (tsel & (wsel == WIN_SETUP)),
      .wdata_i    (bus_wdata),
      .rst_en_i   (mask_q[i]),
      .cmp1_o     (rd_word[i][0]),
      .cmp2_o     (rd_word[i][1]),
      .cnt_o      (rd_word[i][2]),
      .setup_o    (rd_word[i][3]),
      .rst_req_o  (rst_req[i]),
      .evt_o      (evt_out[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (tidx == IDX_W'(i)) bus_rdata = rd_word[i][wsel];
      end
      if (mask_sel) bus_rdata = DW'(mask_q);
    end
  end

  // R9
  rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req & ~mask_q) == '0);

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (rst_req == '0 && evt_out == '0));

endmodule

// File: tb/tb_mfgpt_bank.sv
module tb_mfgpt_bank;

  localparam int NT = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tick_a, tick_b;
  logic [NT-1:0] rst_req, evt_out;

  int n_tests = 0;
  int n_fail  = 0;

  mfgpt_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_a(tick_a),
    .tick_b(tick_b), .rst_req(rst_req), .evt_out(evt_out)
  );

  always #4 clk = ~clk;

  // reference model state
  logic [15:0] m_cmp1 [NT];
  logic [15:0] m_cmp2 [NT];
  logic [15:0] m_cnt  [NT];
  logic [12:0] m_cfg  [NT];
  logic        m_lock [NT];
  logic        m_run  [NT];
  logic        m_f1   [NT];
  logic        m_f2   [NT];
  logic        m_f2d  [NT];
  int          m_div  [NT];
  logic [NT-1:0] m_mask;

  logic [15:0]   last_rd;
  logic [NT-1:0] last_rst, last_evt;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      m_cmp1[t] = 0; m_cmp2[t] = 0; m_cnt[t] = 0; m_cfg[t] = 0;
      m_lock[t] = 0; m_run[t] = 0; m_f1[t] = 0; m_f2[t] = 0;
      m_f2d[t] = 0; m_div[t] = 0;
    end
    m_mask = 0;
  endtask

  function automatic logic fires(input logic [1:0] md, input logic [15:0] v,
                                 input logic [15:0] c);
    if (md == 2'd0) return 1'b0;
    if (md == 2'd2) return v >= c;
    return v == c;
  endfunction

  function automatic logic [15:0] exp_read(input logic [5:0] a);
    int idx, w;
    if (a[0]) return 16'h0;
    idx = int'(a) / 8;
    w = (int'(a) / 2) % 4;
    if (idx < NT) begin
      if (w == 0) return m_cmp1[idx];
      if (w == 1) return m_cmp2[idx];
      if (w == 2) return m_cnt[idx];
      return {m_run[idx], m_f2[idx], m_f1[idx], m_cfg[idx] & 13'h1BFF};
    end
    if (int'(a) / 2 == NT * 4) return {10'd0, m_mask};
    return 16'h0;
  endfunction

  function automatic logic [NT-1:0] exp_rst();
    logic [NT-1:0] r;
    for (int t = 0; t < NT; t++) r[t] = m_f2[t] & ~m_f2d[t] & m_mask[t];
    return r;
  endfunction

  function automatic logic [NT-1:0] exp_evt();
    logic [NT-1:0] r;
    for (int t = 0; t < NT; t++)
      r[t] = (m_f1[t] && m_cfg[t][7:6] == 2'd3) || (m_f2[t] && m_cfg[t][9:8] == 2'd3);
    return r;
  endfunction

  task automatic model_step(input logic wr, input logic [5:0] a, input logic [15:0] d,
                            input logic ta, input logic tb);
    int idx, w;
    idx = int'(a) / 8;
    w = (int'(a) / 2) % 4;
    for (int t = 0; t < NT; t++) begin
      logic tk, st, h1, h2, wcnt, wset;
      logic [15:0] nc;
      int lim;
      st = 0; h1 = 0; h2 = 0;
      tk = m_cfg[t][4] ? tb : ta;
      lim = (1 << m_cfg[t][3:0]) - 1;
      if (!m_run[t]) m_div[t] = 0;
      else if (tk) begin
        if (m_div[t] == lim) begin st = 1; m_div[t] = 0; end
        else m_div[t] = m_div[t] + 1;
      end
      wcnt = wr && !a[0] && idx == t && w == 2;
      wset = wr && !a[0] && idx == t && w == 3;
      nc = m_cnt[t] + 16'd1;
      if (st && !wcnt) begin
        h1 = fires(m_cfg[t][7:6], nc, m_cmp1[t]);
        h2 = fires(m_cfg[t][9:8], nc, m_cmp2[t]);
      end
      m_f2d[t] = m_f2[t];
      m_f1[t] = (m_f1[t] && !(wset && d[13])) || h1;
      m_f2[t] = (m_f2[t] && !(wset && d[14])) || h2;
      if (wcnt) m_cnt[t] = d;
      else if (st) m_cnt[t] = nc;
      if (wr && !a[0] && idx == t && w == 0) m_cmp1[t] = d;
      if (wr && !a[0] && idx == t && w == 1) m_cmp2[t] = d;
      if (wset) begin
        m_run[t] = d[15];
        if (!m_lock[t]) begin m_cfg[t] = d[12:0]; m_lock[t] = 1; end
      end
    end
    if (wr && !a[0] && int'(a) / 2 == NT * 4) m_mask = d[NT-1:0];
  endtask

  // one bus cycle, called just after a falling edge
  task automatic cyc(input logic wr, input logic [5:0] a, input logic [15:0] d,
                     input logic ta, input logic tb);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_a = ta; tick_b = tb;
    #1;
    last_rd = bus_rdata; last_rst = rst_req; last_evt = evt_out;
    chk(last_rd == exp_read(a), "R1/R3 read data", {16'h0, last_rd}, {16'h0, exp_read(a)});
    chk(last_rst == exp_rst(), "R9 reset request", 32'(last_rst), 32'(exp_rst()));
    chk(last_evt == exp_evt(), "R10 event output", 32'(last_evt), 32'(exp_evt()));
    model_step(wr, a, d, ta, tb);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired before R1..R10 checks completed");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic allz;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; tick_a = 0; tick_b = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 reset state over the whole address space
    allz = 1;
    for (int a = 0; a < 64; a++) begin
      cyc(0, 6'(a), 16'h0, 1, 1);
      if (last_rd != 0 || last_rst != 0 || last_evt != 0) allz = 0;
    end
    chk(allz, "R2 all registers zero after reset", 32'(allz), 32'd1);

    // timer 0: equal on cmp1, event mode on cmp2, mask set
    cyc(1, 6'h30, 16'h0001, 0, 0);
    cyc(1, 6'h02, 16'h0003, 0, 0);
    cyc(1, 6'h00, 16'h0002, 0, 0);
    cyc(1, 6'h06, 16'h8340, 0, 0);
    repeat (3) cyc(0, 6'h04, 16'h0, 1, 0);
    cyc(0, 6'h06, 16'h0, 0, 0);
    chk(last_rd == 16'hE340, "R7 both flags after stepping to 3", {16'h0, last_rd}, 32'hE340);
    chk(last_rst[0] == 1'b1, "R9 pulse after cmp2 flag rises", 32'(last_rst[0]), 32'd1);
    chk(last_evt[0] == 1'b1, "R10 event level in mode 3", 32'(last_evt[0]), 32'd1);
    cyc(0, 6'h04, 16'h0, 0, 0);
    chk(last_rst[0] == 1'b0, "R9 pulse lasts one cycle", 32'(last_rst[0]), 32'd0);
    chk(last_rd == 16'h0003, "R6 count value", {16'h0, last_rd}, 32'h3);
    cyc(1, 6'h06, 16'h0005, 0, 0);
    cyc(0, 6'h06, 16'h0, 0, 0);
    chk(last_rd == 16'h6340, "R3 config locked after first write", {16'h0, last_rd}, 32'h6340);
    cyc(1, 6'h06, 16'h2000, 0, 0);
    cyc(0, 6'h06, 16'h0, 0, 0);
    chk(last_rd == 16'h4340, "R8 write-one clears flag 1 only", {16'h0, last_rd}, 32'h4340);
    repeat (4) cyc(0, 6'h04, 16'h0, 1, 1);
    chk(last_rd == 16'h0003, "R6 counter holds while stopped", {16'h0, last_rd}, 32'h3);
    cyc(1, 6'h04, 16'hFFFE, 0, 0);
    cyc(1, 6'h06, 16'h8000, 0, 0);
    cyc(0, 6'h04, 16'h0, 1, 0);
    cyc(0, 6'h04, 16'h0, 1, 0);
    cyc(0, 6'h04, 16'h0, 0, 0);
    chk(last_rd == 16'h0000, "R6 wrap from FFFF to 0", {16'h0, last_rd}, 32'h0);
    cyc(1, 6'h04, 16'h0100, 1, 0);
    cyc(0, 6'h04, 16'h0, 0, 0);
    chk(last_rd == 16'h0100, "R6 bus load beats advance", {16'h0, last_rd}, 32'h100);
    cyc(1, 6'h06, 16'h0000, 0, 0);

    // timer 1: prescale 4 on tick_b
    cyc(1, 6'h0E, 16'h8012, 0, 0);
    for (int k = 0; k < 8; k++) cyc(0, 6'h0C, 16'h0, 1'(k), 1);
    repeat (5) cyc(0, 6'h0C, 16'h0, 1, 0);
    chk(last_rd == 16'h0002, "R4/R5 divide by 4 on tick_b only", {16'h0, last_rd}, 32'h2);

    // timer 2: GE on cmp2, mode 0 on cmp1, mask bit clear
    cyc(1, 6'h12, 16'h0010, 0, 0);
    cyc(1, 6'h10, 16'h0021, 0, 0);
    cyc(1, 6'h14, 16'h0020, 0, 0);
    cyc(1, 6'h16, 16'h8200, 0, 0);
    cyc(0, 6'h16, 16'h0, 1, 0);
    cyc(0, 6'h16, 16'h0, 0, 0);
    chk(last_rd == 16'hC200, "R7 GE fires, mode 0 silent", {16'h0, last_rd}, 32'hC200);
    chk(last_rst[2] == 1'b0, "R9 masked timer no request", 32'(last_rst[2]), 32'd0);
    chk(last_evt[2] == 1'b0, "R10 no event outside mode 3", 32'(last_evt[2]), 32'd0);

    // R1 unmapped and odd addresses
    cyc(1, 6'h38, 16'hFFFF, 0, 0);
    cyc(0, 6'h38, 16'h0, 0, 0);
    chk(last_rd == 16'h0, "R1 unmapped word reads zero", {16'h0, last_rd}, 32'h0);
    cyc(1, 6'h0B, 16'h1234, 0, 0);
    cyc(0, 6'h0A, 16'h0, 0, 0);
    chk(last_rd == 16'h0, "R1 odd write ignored", {16'h0, last_rd}, 32'h0);
    cyc(0, 6'h1E, 16'h0, 0, 0);
    chk(last_rd == 16'h0, "R2 unclaimed timer setup reads zero", {16'h0, last_rd}, 32'h0);

    // constrained random phase, model checked each cycle
    for (int n = 0; n < 4000; n++) begin
      logic wr;
      logic [5:0] a;
      logic [15:0] d;
      int w;
      wr = ($urandom % 100) < 25;
      a = 6'($urandom % 64);
      if ($urandom % 8 != 0) a[0] = 1'b0;
      w = (int'(a) / 2) % 4;
      d = 16'($urandom);
      if (a < 6'h30) begin
        if (w < 2) d = 16'($urandom % 24);
        else if (w == 2) d = ($urandom % 4 == 0) ? 16'hFFF0 | 16'($urandom % 16)
                                                  : 16'($urandom % 16);
        else begin
          d[3:0] = 4'($urandom % 3);
          d[15] = ($urandom % 4) != 0;
        end
      end
      cyc(wr, a, d, 1'($urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule